// File: doc/BRIEF.md
# Buffered Serial Transmitter with Queue Status

This block is the transmit half of a classic byte-serial port. A producer pushes bytes through a valid/ready write port into a byte queue. The queue feeds a ten-bit frame shifter that drives the line. Each character goes out as one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line rests high. Bit timing comes from an internal divider on the system clock. One bit lasts `baud_div + 1` clock cycles.

The drained flag follows the queue output, not the line. It rises in the same cycle that the last queued byte enters the shifter, while that byte is still on the wire. So once it is seen high, the queue has room for a full `DEPTH` bytes on top of the character in flight. Two more outputs support polled bursting: `wr_ready`, which doubles as the queue-not-full flag, and `fifo_level`, the occupancy count. With these, a polling writer can stream bytes without waiting for the drained flag.

The drained interrupt uses the traditional arming rule. It stays quiet after reset until the first byte is accepted. An acknowledge disarms it, and only a later accepted write arms it again. Optional flow control holds back the start of new characters while clear-to-send is low. A character already in progress is never cut short.

Back-pressure rule: the producer must see `wr_ready` high before it raises `wr_valid`. Every cycle with `wr_valid` high is one write attempt. If `wr_ready` is low in that cycle, the byte is discarded and the sticky overflow flag sets.

Top module: `sertx_top`

## Requirements
- R1: The queue holds `DEPTH` bytes (default 16). `wr_ready` is high exactly when fewer than `DEPTH` bytes are queued. A write attempted while it is low does not change `fifo_level`.
- R2: `fifo_level` reports the number of queued bytes. It rises by one per accepted write and falls by one per byte moved into the shifter.
- R3: `fifo_drained` is high whenever the queue is empty. It rises in the same cycle that the last byte enters the shifter, while `tx_idle` stays low during that character.
- R4: When the shifter is idle, a byte written into the empty queue starts its start bit at the next bit tick. That is no more than `baud_div + 3` cycles after the write, which is far short of one character time.
- R5: Each frame is a 0 start bit, eight data bits with bit 0 first, and a 1 stop bit, each lasting `baud_div + 1` cycles. `txd` is 1 when nothing is being sent.
- R6: When the next byte is waiting, its start bit immediately follows the previous stop bit, with no idle gap.
- R7: After reset, `irq` stays low until the first byte is accepted, even though the queue is empty.
- R8: `irq` is high when the interrupt is armed and the queue is empty. An accepted write arms it. An `irq_ack` without an accepted write in the same cycle disarms it, and `irq` stays low until a later accepted write and the following drain.
- R9: A write attempted while the queue is full discards the byte and sets `ovf`. `ovf` stays high until an `ovf_clr` pulse. If a set and a clear happen in the same cycle, the set wins.
- R10: When `flow_en` is 1 and `cts_ok` is 0, no new character starts. A character already started completes normally. When `flow_en` is 0, `cts_ok` has no effect.
- R11: `tx_idle` is high only when the queue is empty and the shifter is not sending. While it is high, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Bit period minus one, in clock cycles |
| flow_en | input | 1 | Enables clear-to-send gating |
| cts_ok | input | 1 | Clear-to-send, high allows a new character |
| wr_valid | input | 1 | Write attempt for `wr_data` |
| wr_ready | output | 1 | Queue not full, the write is accepted |
| wr_data | input | 8 | Byte to queue |
| irq_ack | input | 1 | Acknowledge pulse that disarms the drained interrupt |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| txd | output | 1 | Serial line output, high when idle |
| fifo_drained | output | 1 | Queue empty |
| fifo_level | output | $clog2(DEPTH+1) | Number of queued bytes |
| tx_idle | output | 1 | Queue empty and shifter not sending |
| irq | output | 1 | Drained interrupt request |
| ovf | output | 1 | Sticky write-while-full flag |

## Verification
The bench builds the block with `DEPTH = 8` and drives bit divisors of 3, 5 and 7, so a bit lasts only four to eight clock cycles. This lets it fill the queue and drain it again, frame by frame, within a few thousand cycles. Filling the queue behind a deasserted clear-to-send brings the full boundary and the overflow drop within reach. Two-byte bursts at each divisor expose any gap between back-to-back frames. The bench decodes every frame at mid-bit and compares it against the byte it wrote.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int FRAME_BITS = 10;
  localparam logic START_BIT = 1'b0;
  localparam logic STOP_BIT  = 1'b1;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       avail,
  input  logic       allow,
  input  logic [7:0] din,
  output logic       pop,
  output logic       busy,
  output logic       txd
);
  localparam logic [3:0] LAST = 4'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] frame;
  logic [3:0]            bcnt;
  logic                  slot_free;

  assign slot_free = !busy || (bcnt == LAST);
  assign pop       = tick && slot_free && avail && allow;
  assign txd       = frame[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame <= '1;
      bcnt  <= '0;
      busy  <= 1'b0;
    end else if (tick) begin
      if (!slot_free) begin
        frame <= {1'b1, frame[FRAME_BITS-1:1]};
        bcnt  <= bcnt + 4'd1;
      end else if (avail && allow) begin
        frame <= {STOP_BIT, din, START_BIT};
        bcnt  <= '0;
        busy  <= 1'b1;
      end else begin
        frame <= '1;
        bcnt  <= '0;
        busy  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             flow_en,
  input  logic             cts_ok,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  input  logic             irq_ack,
  input  logic             ovf_clr,
  output logic             txd,
  output logic             fifo_drained,
  output logic [LW-1:0]    fifo_level,
  output logic             tx_idle,
  output logic             irq,
  output logic             ovf
);
  logic tick, push, pop, full, empty, busy, allow, armed;
  logic [7:0] head;

  assign allow    = !flow_en || cts_ok;
  assign push     = wr_valid && !full;
  assign wr_ready = !full;

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  sertx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data), .pop(pop),
    .dout(head), .level(fifo_level), .full(full), .empty(empty)
  );

  sertx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avail(!empty), .allow(allow),
    .din(head), .pop(pop), .busy(busy), .txd(txd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (push)         armed <= 1'b1;
      else if (irq_ack) armed <= 1'b0;
      if (wr_valid && full) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
    end
  end

  assign fifo_drained = empty;
  assign tx_idle      = empty && !busy;
  assign irq          = armed && empty;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          irq_ack,
  input logic          ovf_clr,
  input logic          txd,
  input logic          fifo_drained,
  input logic [LW-1:0] fifo_level,
  input logic          tx_idle,
  input logic          irq,
  input logic          ovf
);
  logic seen_wr;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_wr <= 1'b0;
    else if (wr_valid && wr_ready) seen_wr <= 1'b1;
  end

  a_r1_no_growth_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> fifo_level <= $past(fifo_level));
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));
  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr |-> !irq);
  a_r8_irq_needs_drain: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fifo_drained);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !(wr_valid && wr_ready) |=> !irq);
  a_r9_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> ovf);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  a_r11_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd && fifo_drained);
endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .irq_ack(irq_ack), .ovf_clr(ovf_clr), .txd(txd),
  .fifo_drained(fifo_drained), .fifo_level(fifo_level),
  .tx_idle(tx_idle), .irq(irq), .ovf(ovf)
);

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
  localparam int DEPTH = 8;
  localparam int DIV_W = 16;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NVEC  = 4;
  // each entry: {divisor, first byte, second byte}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd3, 8'h55, 8'hA3}, {8'd5, 8'h00, 8'hFF},
    {8'd7, 8'h81, 8'h7E}, {8'd3, 8'hC4, 8'h19}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] baud_div = 16'd3;
  logic flow_en = 1'b0, cts_ok = 1'b1, wr_valid = 1'b0, irq_ack = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, txd, fifo_drained, tx_idle, irq, ovf;
  logic [LW-1:0] fifo_level;

  int checks = 0, fails = 0, per = 4, cyc = 0;

  always #2.5 clk = ~clk;

  sertx_top #(.DEPTH(DEPTH), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .flow_en(flow_en),
    .cts_ok(cts_ok), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .irq_ack(irq_ack), .ovf_clr(ovf_clr), .txd(txd),
    .fifo_drained(fifo_drained), .fifo_level(fifo_level),
    .tx_idle(tx_idle), .irq(irq), .ovf(ovf));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_data = b; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic set_div(input int d);
    baud_div = DIV_W'(d); per = d + 1;
  endtask

  // waits for a start bit, then samples every bit at its middle
  task automatic rx(output logic [7:0] b, output logic stop, output int waited);
    waited = 0;
    while (txd !== 1'b0 && waited < 5000) begin @(negedge clk); waited++; end
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (per) @(negedge clk);
      b[i] = txd;
    end
    repeat (per) @(negedge clk);
    stop = txd;
  endtask

  task automatic wait_start(output int waited);
    waited = 0;
    while (txd !== 1'b0 && waited < 5000) begin @(negedge clk); waited++; end
  endtask

  logic [7:0] got;
  logic stp;
  int w, lows;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R5 reset txd", txd, 1);
    chk("R2 reset level", fifo_level, 0);
    chk("R1 reset ready", wr_ready, 1);
    chk("R9 reset ovf", ovf, 0);
    chk("R11 reset idle", tx_idle, 1);
    chk("R3 reset drained", fifo_drained, 1);
    repeat (2 * per) @(negedge clk);
    chk("R7 no irq before write", irq, 0);

    // vector table: two-byte bursts at several divisors
    for (int v = 0; v < NVEC; v++) begin
      set_div(int'(VEC[v][23:16]));
      repeat (2 * per) @(negedge clk);
      put(VEC[v][15:8]);
      put(VEC[v][7:0]);
      rx(got, stp, w);
      chk("R5 first byte", got, VEC[v][15:8]);
      chk("R5 first stop", stp, 1);
      rx(got, stp, w);
      chk("R5 second byte", got, VEC[v][7:0]);
      chk("R6 no gap", (w <= per / 2 + 1) ? 1 : 0, 1);
      chk("R5 second stop", stp, 1);
      repeat (per) @(negedge clk);
      chk("R11 idle after burst", tx_idle, 1);
    end

    // load latency, drained flag and interrupt rules
    set_div(5);
    repeat (2 * per) @(negedge clk);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R8 ack disarms", irq, 0);
    put(8'h96);
    wait_start(w);
    chk("R4 load latency", (w <= per + 2) ? 1 : 0, 1);
    chk("R3 drained while sending", fifo_drained, 1);
    chk("R3 not idle while sending", tx_idle, 0);
    chk("R2 level after load", fifo_level, 0);
    chk("R8 irq after drain", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R8 irq cleared by ack", irq, 0);
    rx(got, stp, w);
    chk("R5 byte under irq", got, 8'h96);
    repeat (3 * per) @(negedge clk);
    chk("R8 stays low without write", irq, 0);
    put(8'h2D);
    wait_start(w);
    chk("R8 rearmed by write", irq, 1);
    rx(got, stp, w);
    chk("R5 rearm byte", got, 8'h2D);
    repeat (per) @(negedge clk);

    // flow control holds a new character
    set_div(3);
    flow_en = 1'b1; cts_ok = 1'b0;
    put(8'h3C);
    lows = 0;
    for (int i = 0; i < 4 * per; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    chk("R10 held by cts", lows, 0);
    chk("R10 byte stays queued", fifo_level, 1);
    cts_ok = 1'b1;
    rx(got, stp, w);
    chk("R10 sent after cts", got, 8'h3C);
    repeat (per) @(negedge clk);
    put(8'hA5); put(8'h5A);
    wait_start(w);
    cts_ok = 1'b0;
    rx(got, stp, w);
    chk("R10 in-progress completes", got, 8'hA5);
    lows = 0;
    for (int i = 0; i < 3 * per; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    chk("R10 next held", lows, 0);
    chk("R10 next queued", fifo_level, 1);
    flow_en = 1'b0;
    rx(got, stp, w);
    chk("R10 cts ignored when disabled", got, 8'h5A);
    repeat (per) @(negedge clk);

    // fill to the boundary, overflow, then drain
    flow_en = 1'b1; cts_ok = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      put(8'(8'h10 + i));
      if (i == 2) chk("R2 level counts writes", fifo_level, 3);
    end
    chk("R1 level full", fifo_level, DEPTH);
    chk("R1 ready low when full", wr_ready, 0);
    chk("R9 no ovf yet", ovf, 0);
    put(8'hEE);
    chk("R9 ovf set", ovf, 1);
    chk("R1 level unchanged", fifo_level, DEPTH);
    repeat (2) @(negedge clk);
    chk("R9 ovf sticky", ovf, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R9 ovf cleared", ovf, 0);
    cts_ok = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      rx(got, stp, w);
      chk("R1 drained order", got, 8'h10 + i);
    end
    flow_en = 1'b0;
    lows = 0;
    for (int i = 0; i < 3 * per; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
    chk("R9 dropped byte never sent", lows, 0);
    chk("R11 idle at end", tx_idle, 1);
    chk("R2 level empty at end", fifo_level, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule